// File: doc/BRIEF.md
# GPIO Interrupt Channel Mux

This block takes a wide bank of GPIO pad inputs and folds them onto a small set of interrupt channels that feed a parent interrupt controller. For each channel, software chooses which pad it watches. It then picks one of three ways to turn that pad into an interrupt: follow the level, pulse on a single edge, or pulse on every transition. It can also ask for the pad to be inverted first and set a per-channel debounce length. Pads are synchronised to the block clock before selection. The output toward the parent is always active-high. Active-low levels and falling edges are handled by inverting the selected pad before the filter and the detector, so the parent only ever needs to accept high levels and rising edges.

Configuration goes through a plain 32-bit register port. Writes are captured on the clock edge. Reads are combinational from the stored registers. Each channel's interrupt line is a level in level mode and a single-cycle pulse in either edge mode.

Top module: `gpio_irq_mux`

## Requirements
- R1: After reset all four registers read zero and every channel is in level mode, watching pad 0, with no inversion and no filtering, so every `irq_o` bit is 0 while the pads are low.
- R2: The control word at byte offset 0x00 holds, per channel c, edge mode at bit c, both-edge mode at bit 8+c and input inversion at bit 16+c; bits 24 to 31 are not stored and read as zero.
- R3: Pad selection uses 8-bit fields: channels 0 to 3 at offset 0x04 and channels 4 to 7 at offset 0x08, channel c at bits (c mod 4)*8 upward; any of the 256 pads, including pad 255, can be routed to any channel.
- R4: The filter word at offset 0x0C holds a 4-bit length N for channel c at bits 4c upward.
- R5: With the filter bypassed (N = 0), a pad change applied before a rising clock edge shows on a level-mode channel output after the third rising edge, passing two synchroniser stages and one filter stage.
- R6: In level mode the channel output equals the filtered, optionally inverted pad level; with inversion set, a low pad gives a high output.
- R7: In edge mode, with both-edge off, each rising edge of the filtered (optionally inverted) signal gives exactly one output pulse one clock wide, so inversion turns a falling pad edge into a pulse and a rising pad edge gives none.
- R8: With both-edge set, every rising and falling transition of the filtered pad gives a one-cycle pulse, and the edge and inversion bits of that channel have no effect.
- R9: With N > 0 the filtered value changes only after the synchronised input has differed from it on 2N consecutive clock edges; any shorter excursion leaves the output unchanged.
- R10: A register write takes effect on the clock edge that samples it and reads back from the following cycle; `rd_data` is a combinational function of `rd_addr` and the stored registers.
- R11: Reads of any byte offset other than 0x00, 0x04, 0x08 and 0x0C return zero, and writes to them change no register and no output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| pad_i | input | 256 | Asynchronous GPIO pad levels |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 5 | Byte offset of the write |
| wr_data | input | 32 | Write data |
| rd_addr | input | 5 | Byte offset of the read |
| rd_data | output | 32 | Read data, combinational |
| irq_o | output | 8 | Active-high interrupt per channel toward the parent |

## Verification
The bench aims at the pipeline depth from pad to output. If a synchroniser stage is missing or doubled, the output rises one edge early or late. It probes a glitch that is one cycle short of the filter window; an off-by-one filter counter would either let it through or swallow the genuine change that follows. It drives an inverted edge channel with a rising pad, which must produce no pulse. It also drives a both-edge channel with the inversion bit set, where a design that still applied the inversion would emit a spurious pulse the moment the mode is written. Field positions are checked with pad 255 on channel 7 and a filter nibble at the top of the word, and unmapped writes are followed by readback of every real register.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

  localparam int DATA_W       = 32;
  // spacing between the three per-channel bit groups of the control word
  localparam int FIELD_STRIDE = 8;

  typedef enum logic [1:0] {
    TRIG_LEVEL = 2'd0,
    TRIG_EDGE  = 2'd1,
    TRIG_BOTH  = 2'd2
  } trig_mode_e;

  // both-edge wins over the single-edge bit
  function automatic trig_mode_e decode_mode(input logic edge_bit, input logic both_bit);
    if (both_bit)      return TRIG_BOTH;
    else if (edge_bit) return TRIG_EDGE;
    else               return TRIG_LEVEL;
  endfunction

endpackage

// File: rtl/gpio_irq_sync.sv
module gpio_irq_sync #(
  parameter int WIDTH = 256
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);

  logic [WIDTH-1:0] meta_q;
  logic [WIDTH-1:0] stable_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q   <= '0;
      stable_q <= '0;
    end else begin
      meta_q   <= async_i;
      stable_q <= meta_q;
    end
  end

  assign sync_o = stable_q;

endmodule

// File: rtl/gpio_irq_regs.sv
module gpio_irq_regs
  import gpio_irq_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int SEL_W  = 8,
  parameter int FILT_W = 4,
  parameter int ADDR_W = 5
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [ADDR_W-1:0]        wr_addr,
  input  logic [DATA_W-1:0]        wr_data,
  input  logic [ADDR_W-1:0]        rd_addr,
  output logic [DATA_W-1:0]        rd_data,
  output logic [NUM_CH-1:0]        edge_en,
  output logic [NUM_CH-1:0]        both_en,
  output logic [NUM_CH-1:0]        inv_en,
  output logic [NUM_CH*SEL_W-1:0]  sel_flat,
  output logic [NUM_CH*FILT_W-1:0] filt_flat
);

  localparam int WORD_W       = ADDR_W - 2;
  localparam int SEL_PER_REG  = DATA_W / SEL_W;
  localparam int NUM_SEL_REGS = NUM_CH / SEL_PER_REG;
  localparam int FILT_BITS    = NUM_CH * FILT_W;
  localparam int SEL_BASE     = 1;
  localparam int FILT_IDX     = SEL_BASE + NUM_SEL_REGS;

  localparam logic [WORD_W-1:0] CTRL_WORD = WORD_W'(0);
  localparam logic [WORD_W-1:0] FILT_WORD = WORD_W'(FILT_IDX);
  localparam logic [DATA_W-1:0] CH_ONES   = DATA_W'((64'd1 << NUM_CH) - 64'd1);
  localparam logic [DATA_W-1:0] CTRL_MASK = CH_ONES
                                          | (CH_ONES << FIELD_STRIDE)
                                          | (CH_ONES << (2 * FIELD_STRIDE));

  logic [DATA_W-1:0]                    ctrl_q, ctrl_d;
  logic [NUM_SEL_REGS-1:0][DATA_W-1:0]  sel_q, sel_d;
  logic [FILT_BITS-1:0]                 filt_q, filt_d;

  logic              wr_hit;
  logic [WORD_W-1:0] wr_word;
  logic              rd_aligned;
  logic [WORD_W-1:0] rd_word;

  assign wr_hit     = wr_en && (wr_addr[1:0] == 2'b00);
  assign wr_word    = wr_addr[ADDR_W-1:2];
  assign rd_aligned = (rd_addr[1:0] == 2'b00);
  assign rd_word    = rd_addr[ADDR_W-1:2];

  // next-state
  always_comb begin
    ctrl_d = ctrl_q;
    sel_d  = sel_q;
    filt_d = filt_q;
    if (wr_hit) begin
      if (wr_word == CTRL_WORD) ctrl_d = wr_data & CTRL_MASK;
      for (int k = 0; k < NUM_SEL_REGS; k++) begin
        if (wr_word == WORD_W'(SEL_BASE + k)) sel_d[k] = wr_data;
      end
      if (wr_word == FILT_WORD) filt_d = wr_data[FILT_BITS-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      sel_q  <= '0;
      filt_q <= '0;
    end else if (wr_hit) begin
      ctrl_q <= ctrl_d;
      sel_q  <= sel_d;
      filt_q <= filt_d;
    end
  end

  // read mux
  always_comb begin
    rd_data = '0;
    if (rd_aligned) begin
      if (rd_word == CTRL_WORD) rd_data = ctrl_q;
      for (int k = 0; k < NUM_SEL_REGS; k++) begin
        if (rd_word == WORD_W'(SEL_BASE + k)) rd_data = sel_q[k];
      end
      if (rd_word == FILT_WORD) rd_data = DATA_W'(filt_q);
    end
  end

  assign edge_en   = ctrl_q[0 +: NUM_CH];
  assign both_en   = ctrl_q[FIELD_STRIDE +: NUM_CH];
  assign inv_en    = ctrl_q[2*FIELD_STRIDE +: NUM_CH];
  assign sel_flat  = sel_q;
  assign filt_flat = filt_q;

endmodule

// File: rtl/gpio_irq_chan.sv
module gpio_irq_chan
  import gpio_irq_pkg::*;
#(
  parameter int SEL_W  = 8,
  parameter int FILT_W = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [(1<<SEL_W)-1:0] pads_sync,
  input  logic [SEL_W-1:0]      pad_sel,
  input  logic [FILT_W-1:0]     filt_len,
  input  logic                  edge_en,
  input  logic                  both_en,
  input  logic                  inv_en,
  output logic                  irq
);

  localparam int CNT_W = FILT_W + 1;

  trig_mode_e       mode;
  logic             pad_raw;
  logic             cond;
  logic [CNT_W-1:0] limit;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             filt_q, filt_d;
  logic             prev_q;

  assign mode    = decode_mode(edge_en, both_en);
  assign pad_raw = pads_sync[pad_sel];
  // inversion only applies outside both-edge mode
  assign cond    = pad_raw ^ (inv_en & ~both_en);
  assign limit   = {filt_len, 1'b0};

  // filter next-state
  always_comb begin
    filt_d = filt_q;
    cnt_d  = cnt_q;
    if (filt_len == '0) begin
      filt_d = cond;
      cnt_d  = '0;
    end else if (cond == filt_q) begin
      cnt_d  = '0;
    end else if (cnt_q + 1'b1 == limit) begin
      filt_d = cond;
      cnt_d  = '0;
    end else begin
      cnt_d  = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      filt_q <= 1'b0;
      cnt_q  <= '0;
      prev_q <= 1'b0;
    end else begin
      filt_q <= filt_d;
      cnt_q  <= cnt_d;
      prev_q <= filt_q;
    end
  end

  always_comb begin
    case (mode)
      TRIG_EDGE: irq = filt_q & ~prev_q;
      TRIG_BOTH: irq = filt_q ^ prev_q;
      default:   irq = filt_q;
    endcase
  end

endmodule

// File: rtl/gpio_irq_mux.sv
module gpio_irq_mux
  import gpio_irq_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int SEL_W  = 8,
  parameter int FILT_W = 4,
  parameter int ADDR_W = 5
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [(1<<SEL_W)-1:0]  pad_i,
  input  logic                   wr_en,
  input  logic [ADDR_W-1:0]      wr_addr,
  input  logic [DATA_W-1:0]      wr_data,
  input  logic [ADDR_W-1:0]      rd_addr,
  output logic [DATA_W-1:0]      rd_data,
  output logic [NUM_CH-1:0]      irq_o
);

  localparam int NUM_PADS = 1 << SEL_W;

  logic                     rst_meta_q;
  logic                     rst_sync_n;
  logic [NUM_PADS-1:0]      pads_sync;
  logic [NUM_CH-1:0]        edge_en;
  logic [NUM_CH-1:0]        both_en;
  logic [NUM_CH-1:0]        inv_en;
  logic [NUM_CH*SEL_W-1:0]  sel_flat;
  logic [NUM_CH*FILT_W-1:0] filt_flat;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  gpio_irq_sync #(.WIDTH(NUM_PADS)) u_sync (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .async_i (pad_i),
    .sync_o  (pads_sync)
  );

  gpio_irq_regs #(
    .NUM_CH (NUM_CH),
    .SEL_W  (SEL_W),
    .FILT_W (FILT_W),
    .ADDR_W (ADDR_W)
  ) u_regs (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .rd_addr   (rd_addr),
    .rd_data   (rd_data),
    .edge_en   (edge_en),
    .both_en   (both_en),
    .inv_en    (inv_en),
    .sel_flat  (sel_flat),
    .filt_flat (filt_flat)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
    gpio_irq_chan #(
      .SEL_W  (SEL_W),
      .FILT_W (FILT_W)
    ) u_chan (
      .clk       (clk),
      .rst_n     (rst_sync_n),
      .pads_sync (pads_sync),
      .pad_sel   (sel_flat[c*SEL_W +: SEL_W]),
      .filt_len  (filt_flat[c*FILT_W +: FILT_W]),
      .edge_en   (edge_en[c]),
      .both_en   (both_en[c]),
      .inv_en    (inv_en[c]),
      .irq       (irq_o[c])
    );
  end

endmodule

// File: rtl/gpio_irq_checks.sv
module gpio_irq_checks
  import gpio_irq_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int SEL_W  = 8,
  parameter int FILT_W = 4,
  parameter int ADDR_W = 5
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     wr_en,
  input logic [ADDR_W-1:0]        wr_addr,
  input logic [DATA_W-1:0]        wr_data,
  input logic [ADDR_W-1:0]        rd_addr,
  input logic [DATA_W-1:0]        rd_data,
  input logic [NUM_CH-1:0]        irq_o,
  input logic [NUM_CH-1:0]        edge_en,
  input logic [NUM_CH-1:0]        both_en,
  input logic [NUM_CH-1:0]        inv_en,
  input logic [NUM_CH*SEL_W-1:0]  sel_flat,
  input logic [NUM_CH*FILT_W-1:0] filt_flat
);

  localparam int NUM_WORDS = 2 + (NUM_CH * SEL_W) / DATA_W;

  function automatic logic unmapped(input logic [ADDR_W-1:0] a);
    return (a[1:0] != 2'b00) || (int'(a[ADDR_W-1:2]) >= NUM_WORDS);
  endfunction

  AST_CTRL_WRITE_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == '0) |=> (edge_en == $past(wr_data[0 +: NUM_CH]) &&
                                  both_en == $past(wr_data[FIELD_STRIDE +: NUM_CH]) &&
                                  inv_en  == $past(wr_data[2*FIELD_STRIDE +: NUM_CH]))); // R10

  AST_SEL_WRITE_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == ADDR_W'(4)) |=> (sel_flat[DATA_W-1:0] == $past(wr_data))); // R3

  AST_UNMAPPED_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && unmapped(wr_addr)) |=> ($stable(edge_en) && $stable(both_en) && $stable(inv_en) &&
                                      $stable(sel_flat) && $stable(filt_flat))); // R11

  AST_UNMAPPED_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    unmapped(rd_addr) |-> (rd_data == '0)); // R11

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
    AST_EDGE_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      (edge_en[c] && !both_en[c] && irq_o[c] && !wr_en) |=> !irq_o[c]); // R7
  end

endmodule

bind gpio_irq_mux gpio_irq_checks #(
  .NUM_CH (NUM_CH),
  .SEL_W  (SEL_W),
  .FILT_W (FILT_W),
  .ADDR_W (ADDR_W)
) u_checks (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .wr_en     (wr_en),
  .wr_addr   (wr_addr),
  .wr_data   (wr_data),
  .rd_addr   (rd_addr),
  .rd_data   (rd_data),
  .irq_o     (irq_o),
  .edge_en   (edge_en),
  .both_en   (both_en),
  .inv_en    (inv_en),
  .sel_flat  (sel_flat),
  .filt_flat (filt_flat)
);

// File: tb/test_gpio_irq_mux.sv
module test_gpio_irq_mux;

  localparam int CLK_PERIOD = 10;
  localparam int NCH   = 8;
  localparam int NPADS = 256;

  logic             clk;
  logic             rst_n;
  logic [NPADS-1:0] pad_i;
  logic             wr_en;
  logic [4:0]       wr_addr;
  logic [31:0]      wr_data;
  logic [4:0]       rd_addr;
  logic [31:0]      rd_data;
  logic [NCH-1:0]   irq_o;

  int    n_checks;
  int    n_errors;
  bit    done;
  bit    chk_on;
  string phase_req;

  gpio_irq_mux i_gpio_irq_mux (
    .clk     (clk),
    .rst_n   (rst_n),
    .pad_i   (pad_i),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .rd_addr (rd_addr),
    .rd_data (rd_data),
    .irq_o   (irq_o)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // ---------------- reference model, from the requirements ----------------
  logic [NPADS-1:0] m_s1, m_s2;
  logic [31:0]      m_ctrl, m_filt;
  logic [1:0][31:0] m_sel;
  logic [NCH-1:0]   m_fq, m_prev;
  int               m_cnt [NCH];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_s1 = '0; m_s2 = '0; m_ctrl = '0; m_filt = '0; m_sel = '0;
      m_fq = '0; m_prev = '0;
      for (int c = 0; c < NCH; c++) m_cnt[c] = 0;
    end else begin
      for (int c = 0; c < NCH; c++) begin
        logic [7:0] s;
        logic       b, x;
        int         n;
        s = m_sel[c/4][(c%4)*8 +: 8];
        b = m_ctrl[8+c];
        x = m_s2[s] ^ (m_ctrl[16+c] & ~b);
        n = int'(m_filt[c*4 +: 4]);
        m_prev[c] = m_fq[c];
        if (n == 0) begin
          m_fq[c] = x; m_cnt[c] = 0;
        end else if (x == m_fq[c]) begin
          m_cnt[c] = 0;
        end else if (m_cnt[c] + 1 == 2*n) begin
          m_fq[c] = x; m_cnt[c] = 0;
        end else begin
          m_cnt[c] = m_cnt[c] + 1;
        end
      end
      m_s2 = m_s1;
      m_s1 = pad_i;
      if (wr_en) begin
        case (wr_addr)
          5'h00: m_ctrl = wr_data & 32'h00FF_FFFF;
          5'h04: m_sel[0] = wr_data;
          5'h08: m_sel[1] = wr_data;
          5'h0C: m_filt = wr_data;
          default: ;
        endcase
      end
    end
  end

  function automatic logic [NCH-1:0] exp_irq();
    logic [NCH-1:0] r;
    for (int c = 0; c < NCH; c++) begin
      if (m_ctrl[8+c])      r[c] = m_fq[c] ^ m_prev[c];
      else if (m_ctrl[c])   r[c] = m_fq[c] & ~m_prev[c];
      else                  r[c] = m_fq[c];
    end
    return r;
  endfunction

  // ---------------- checking ----------------
  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s %s: actual=0x%08h expected=0x%08h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (chk_on && !done) check(phase_req, "irq_o vs model", 32'(irq_o), 32'(exp_irq()));
  end

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++;
    n_errors++;
    $display("FAIL watchdog: actual=expired expected=finished");
    finish_run();
  end

  // ---------------- drivers ----------------
  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    rd_addr = a;
    #1;
    d = rd_data;
  endtask

  task automatic rd_check(input string req, input logic [4:0] a, input logic [31:0] exp);
    logic [31:0] d;
    rd(a, d);
    check(req, $sformatf("read 0x%02h", a), d, exp);
  endtask

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic count_high(input int ch, input int n, output int hi);
    hi = 0;
    repeat (n) begin
      @(negedge clk);
      #1;
      if (irq_o[ch]) hi++;
    end
  endtask

  initial begin
    logic [31:0] saved [4];
    logic [31:0] d;
    int          hi;
    n_checks = 0; n_errors = 0; done = 1'b0; chk_on = 1'b0; phase_req = "R1";
    rst_n = 1'b0; pad_i = '0; wr_en = 1'b0; wr_addr = '0; wr_data = '0; rd_addr = '0;
    cycles(3);
    rst_n = 1'b1;
    cycles(4);
    chk_on = 1'b1;

    // R1: reset state
    check("R1", "irq_o after reset", 32'(irq_o), 32'h0);
    rd_check("R1", 5'h00, 32'h0);
    rd_check("R1", 5'h04, 32'h0);
    rd_check("R1", 5'h08, 32'h0);
    rd_check("R1", 5'h0C, 32'h0);

    // R2: control word layout, upper byte not stored
    phase_req = "R2";
    wr(5'h00, 32'hFFFF_FFFF);
    rd_check("R2", 5'h00, 32'h00FF_FFFF);
    wr(5'h00, 32'h0);
    cycles(4);

    // R10: write visible on the cycle after
    phase_req = "R10";
    wr(5'h04, 32'h0000_0005);
    rd_check("R10", 5'h04, 32'h0000_0005);
    cycles(3);

    // R5: latency with filter bypassed, ch0 level on pad 5
    phase_req = "R5";
    pad_i[5] = 1'b1;
    @(negedge clk); #1; check("R5", "irq0 after edge 1", 32'(irq_o[0]), 32'h0);
    @(negedge clk); #1; check("R5", "irq0 after edge 2", 32'(irq_o[0]), 32'h0);
    @(negedge clk); #1; check("R5", "irq0 after edge 3", 32'(irq_o[0]), 32'h1);

    // R9: filter length 2 needs four edges; three-cycle glitch is dropped
    phase_req = "R9";
    wr(5'h0C, 32'h0000_0002);
    cycles(2);
    pad_i[5] = 1'b0;
    cycles(3);
    pad_i[5] = 1'b1;
    count_high(0, 8, hi);
    check("R9", "irq0 high cycles over short glitch", 32'(hi), 32'd8);
    pad_i[5] = 1'b0;
    cycles(5); #1;
    check("R9", "irq0 after 5 edges of held low", 32'(irq_o[0]), 32'h1);
    @(negedge clk); #1;
    check("R9", "irq0 after 6 edges of held low", 32'(irq_o[0]), 32'h0);

    // R6/R7: ch1 on pad 7, edge + invert => falling-edge pulse only
    phase_req = "R7";
    wr(5'h0C, 32'h0);
    wr(5'h04, 32'h0000_0705);
    wr(5'h00, 32'h0002_0002);
    cycles(6);
    pad_i[7] = 1'b1;
    count_high(1, 8, hi);
    check("R7", "pulses on rising pad with invert", 32'(hi), 32'd0);
    pad_i[7] = 1'b0;
    count_high(1, 8, hi);
    check("R7", "pulse cycles on falling pad with invert", 32'(hi), 32'd1);

    // R6: inverted level on ch3 (pad 0 low => high)
    phase_req = "R6";
    wr(5'h00, 32'h0008_0000);
    cycles(2); #1;
    check("R6", "inverted level with low pad", 32'(irq_o[3]), 32'h1);

    // R8: ch2 on pad 9, both-edge with edge and invert also set
    phase_req = "R8";
    wr(5'h04, 32'h0009_0705);
    wr(5'h00, 32'h0004_0404);
    count_high(2, 8, hi);
    check("R8", "no pulse from ignored invert", 32'(hi), 32'd0);
    pad_i[9] = 1'b1;
    count_high(2, 8, hi);
    check("R8", "pulse cycles on rise", 32'(hi), 32'd1);
    pad_i[9] = 1'b0;
    count_high(2, 8, hi);
    check("R8", "pulse cycles on fall", 32'(hi), 32'd1);

    // R3: pad 255 on channel 7, field in top byte of 0x08
    phase_req = "R3";
    wr(5'h00, 32'h0);
    wr(5'h08, 32'hFF00_0000);
    pad_i[255] = 1'b1;
    cycles(4); #1;
    check("R3", "irq7 follows pad 255", 32'(irq_o[7]), 32'h1);
    check("R3", "irq4 stays on pad 0", 32'(irq_o[4]), 32'h0);

    // R4: ch7 filter nibble at bits 31:28, length 3 => 6 edges
    phase_req = "R4";
    wr(5'h0C, 32'h3000_0000);
    pad_i[255] = 1'b0;
    cycles(5);
    pad_i[255] = 1'b1;
    count_high(7, 10, hi);
    check("R4", "irq7 holds through 5-cycle glitch", 32'(hi), 32'd10);

    // R11: unmapped writes and reads
    phase_req = "R11";
    rd(5'h00, saved[0]); rd(5'h04, saved[1]); rd(5'h08, saved[2]); rd(5'h0C, saved[3]);
    wr(5'h10, 32'hFFFF_FFFF);
    wr(5'h06, 32'hFFFF_FFFF);
    wr(5'h1C, 32'hFFFF_FFFF);
    wr(5'h01, 32'hFFFF_FFFF);
    rd_check("R11", 5'h00, saved[0]);
    rd_check("R11", 5'h04, saved[1]);
    rd_check("R11", 5'h08, saved[2]);
    rd_check("R11", 5'h0C, saved[3]);
    rd_check("R11", 5'h10, 32'h0);
    rd_check("R11", 5'h06, 32'h0);
    rd_check("R11", 5'h1C, 32'h0);

    // random phase against the model (R6, R7, R8, R9 combined)
    phase_req = "R6";
    process::self().srandom(32'd1234);
    for (int i = 0; i < 2000; i++) begin
      if ($urandom_range(0, 19) == 0) begin
        logic [4:0]  a;
        logic [31:0] v;
        v = $urandom;
        case ($urandom_range(0, 5))
          0: a = 5'h00;
          1: begin a = 5'h04; v = v & 32'h0F0F_0F0F; end
          2: begin a = 5'h08; v = v & 32'h0F0F_0F0F; end
          3: begin a = 5'h0C; v = v & 32'h3333_3333; end
          4: a = 5'h14;
          default: a = 5'h0A;
        endcase
        wr_en = 1'b1; wr_addr = a; wr_data = v;
      end else begin
        wr_en = 1'b0;
      end
      for (int p = 0; p < 16; p++) begin
        if ($urandom_range(0, 7) == 0) pad_i[p] = ~pad_i[p];
      end
      @(negedge clk);
    end
    wr_en = 1'b0;
    cycles(2);
    rd(5'h00, d);
    check("R2", "ctrl readback after random run", d, m_ctrl);

    finish_run();
  end

endmodule